// File: doc/BRIEF.md
# I2C Target Register Access Engine

This block is a fixed-address I2C target that lets a host read and write a small bank of 8-bit control registers. It oversamples the SCL and SDA lines in a fast system clock, finds start, repeated-start and stop conditions, and takes in the address byte. It acknowledges by pulling SDA low through an open-drain enable output.

After a write address, the first byte always loads an internal register pointer. Each later byte is written to the pointed register, and the pointer then advances. To read, the host sets the pointer with a write, issues a repeated start and sends the address with the direction bit set. The engine then returns bytes from the pointer onward for as long as the host acknowledges. On the register side the block has a plain strobe bus: address, write data, write strobe, read strobe and read data. The strobes are single-cycle and combinational. The address is always the pointer register. Read data is sampled in the cycle of the read strobe.

The system clock must run at least ten times faster than SCL. Clock stretching, 10-bit addressing and general call are not supported.

Top module: `i2c_regport_target`

## Requirements
- R1: Only the 7-bit address 1100000 (the first seven bits after a start, MSB first) is acknowledged. With any other address the engine does not acknowledge and keeps SDA released, ignoring all bytes until the next start or stop.
- R2: Bytes move MSB first in both directions. A target acknowledge holds SDA low across the whole ninth SCL pulse. The eighth bit of the address byte is the direction: 0 for write, 1 for read.
- R3: A start (SDA falls while SCL is high) or a stop (SDA rises while SCL is high) at any point abandons the byte in progress without a write and releases SDA. After a start the engine waits for an address. After a stop it is idle.
- R4: In a write transfer, the byte after the address loads the register pointer and is acknowledged. It produces no write strobe.
- R5: Each further byte of a write transfer gives exactly one write strobe to the pointed register and is acknowledged. The pointer then advances by one.
- R6: With the direction bit set to 1, the engine returns the byte at the pointer. It advances the pointer by one for every byte it loads for transmission, and returns the next byte after each host acknowledge.
- R7: A host not-acknowledge after a read byte makes the engine release SDA and load no further byte.
- R8: Exactly one read strobe is issued for each transmitted byte, at the moment the byte is loaded. The read strobe and the write strobe are never high together.
- R9: After a synchronous active-low reset, the SDA enable and both strobes are low and the pointer is zero.
- R10: The pointer keeps its value across stop and start conditions. It wraps from all ones to zero.
- R11: The SDA enable changes only in the cycle after an SCL falling edge, a start or a stop has been detected. It never changes while SCL is high mid-bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL bus level |
| sda_i | input | 1 | SDA bus level |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| reg_addr | output | AW (8) | Register address, equal to the pointer |
| reg_wdata | output | 8 | Write data, valid with reg_wr |
| reg_wr | output | 1 | Single-cycle write strobe |
| reg_rd | output | 1 | Single-cycle read strobe |
| reg_rdata | input | 8 | Read data, sampled while reg_rd is high |

## Verification
The assertions check, on every cycle, four things. SDA enable changes only after an SCL falling edge or a bus condition. A stop always leaves SDA released. Every write strobe and every read strobe steps the pointer by exactly one. Read strobes are single-cycle and never overlap a write.

Only the directed scenarios can show the transfer-level behaviour:
- which address is acknowledged
- that the pointer byte is not written
- that burst data lands in consecutive registers and comes back MSB first
- that a host not-acknowledge stops further loads
- that a stop in mid-byte discards the partial byte
- that the pointer survives between transfers and wraps

// File: rtl/i2c_tgt_pkg.sv
// Shared types for the I2C target register access engine.
package i2c_tgt_pkg;

    // Protocol state of the byte engine.
    typedef enum logic [2:0] {
        ST_IDLE,   // bus free, waiting for a start
        ST_ADDR,   // shifting in the address byte
        ST_PTR,    // shifting in the register pointer byte
        ST_WDATA,  // shifting in a write data byte
        ST_ACK,    // target drives the acknowledge bit
        ST_TX,     // target shifts out a read byte
        ST_HACK,   // host acknowledge slot after a read byte
        ST_SKIP    // not addressed or read ended: wait for start or stop
    } tgt_state_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/i2c_line_sync.sv
// i2c_line_sync
// Brings the asynchronous SCL and SDA levels into the system clock through
// a STAGES-deep flip-flop chain. It then derives the SCL edges and the
// start and stop conditions.
// Assumes: the system clock is at least 10x SCL, so each bus phase spans
// several clock cycles. Idle bus level is high, and so is the reset value.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_e,
    output logic stop_e,
    output logic sda_lvl
);

    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_p;
    logic              sda_p;
    logic              scl_s;
    logic              sda_s;

    assign scl_s = scl_sh[STAGES-1];
    assign sda_s = sda_sh[STAGES-1];

    // Synchronizer chains plus one delayed copy of each line for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_p  <= scl_s;
            sda_p  <= sda_s;
        end
    end

    // Edge and bus-condition decode from the synchronized and delayed copies.
    always_comb begin
        scl_rise = scl_s & ~scl_p;
        scl_fall = ~scl_s & scl_p;
        start_e  = scl_s & scl_p & sda_p & ~sda_s;
        stop_e   = scl_s & scl_p & ~sda_p & sda_s;
        sda_lvl  = sda_s;
    end

endmodule

// File: rtl/i2c_byte_engine.sv
// i2c_byte_engine
// Protocol engine of the target. It does four things:
// - matches the address byte and acknowledges
// - loads the register pointer
// - issues write strobes for incoming data
// - loads and shifts out read bytes while the host acknowledges
// Bits are sampled on SCL rising edges. SDA is only driven after SCL falling
// edges.
// Assumes: the inputs come from i2c_line_sync. Register read data is valid
// combinationally in the cycle of reg_rd.
module i2c_byte_engine
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b1100000,
    parameter int         AW       = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_e,
    input  logic          stop_e,
    input  logic          sda_lvl,
    output logic          sda_oe,
    output logic [AW-1:0] reg_addr,
    output logic [7:0]    reg_wdata,
    output logic          reg_wr,
    output logic          reg_rd,
    input  logic [7:0]    reg_rdata
);

    localparam int CW = $clog2(BYTE_W + 1);

    tgt_state_e    state_q;
    tgt_state_e    after_q;
    logic          ack_ph_q;
    logic          more_q;
    logic [CW-1:0] bitcnt_q;
    logic [6:0]    rx_q;
    logic [6:0]    tx_q;
    logic [AW-1:0] ptr_q;
    logic          sda_oe_q;

    logic [7:0]    rx_full;
    logic          last_rx;
    logic          wr_now;
    logic          load_now;

    // Decode of the byte boundary and the register-bus strobes.
    always_comb begin
        rx_full   = {rx_q, sda_lvl};
        last_rx   = scl_rise && (bitcnt_q == CW'(BYTE_W - 1));
        wr_now    = (state_q == ST_WDATA) && last_rx && !start_e && !stop_e;
        load_now  = scl_fall && !start_e && !stop_e &&
                    (((state_q == ST_ACK) && ack_ph_q && (after_q == ST_TX)) ||
                     ((state_q == ST_HACK) && more_q));
        reg_wr    = wr_now;
        reg_rd    = load_now;
        reg_wdata = rx_full;
        reg_addr  = ptr_q;
        sda_oe    = sda_oe_q;
    end

    // Protocol state machine, bit counter, shifters and register pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            after_q  <= ST_IDLE;
            ack_ph_q <= 1'b0;
            more_q   <= 1'b0;
            bitcnt_q <= '0;
            rx_q     <= '0;
            tx_q     <= '0;
            ptr_q    <= '0;
            sda_oe_q <= 1'b0;
        end else if (start_e) begin
            state_q  <= ST_ADDR;
            bitcnt_q <= '0;
            ack_ph_q <= 1'b0;
            more_q   <= 1'b0;
            sda_oe_q <= 1'b0;
        end else if (stop_e) begin
            state_q  <= ST_IDLE;
            ack_ph_q <= 1'b0;
            more_q   <= 1'b0;
            sda_oe_q <= 1'b0;
        end else begin
            case (state_q)
                ST_ADDR: begin
                    if (scl_rise) begin
                        rx_q     <= rx_full[6:0];
                        bitcnt_q <= bitcnt_q + CW'(1);
                        if (last_rx) begin
                            bitcnt_q <= '0;
                            if (rx_full[7:1] == DEV_ADDR) begin
                                state_q <= ST_ACK;
                                after_q <= rx_full[0] ? ST_TX : ST_PTR;
                            end else begin
                                state_q <= ST_SKIP;
                            end
                        end
                    end
                end
                ST_PTR: begin
                    if (scl_rise) begin
                        rx_q     <= rx_full[6:0];
                        bitcnt_q <= bitcnt_q + CW'(1);
                        if (last_rx) begin
                            bitcnt_q <= '0;
                            ptr_q    <= AW'(rx_full);
                            state_q  <= ST_ACK;
                            after_q  <= ST_WDATA;
                        end
                    end
                end
                ST_WDATA: begin
                    if (scl_rise) begin
                        rx_q     <= rx_full[6:0];
                        bitcnt_q <= bitcnt_q + CW'(1);
                        if (last_rx) begin
                            bitcnt_q <= '0;
                            ptr_q    <= ptr_q + AW'(1);
                            state_q  <= ST_ACK;
                            after_q  <= ST_WDATA;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        if (!ack_ph_q) begin
                            sda_oe_q <= 1'b1;
                            ack_ph_q <= 1'b1;
                        end else begin
                            ack_ph_q <= 1'b0;
                            bitcnt_q <= '0;
                            if (after_q == ST_TX) begin
                                tx_q     <= reg_rdata[6:0];
                                sda_oe_q <= ~reg_rdata[7];
                                ptr_q    <= ptr_q + AW'(1);
                                state_q  <= ST_TX;
                            end else begin
                                sda_oe_q <= 1'b0;
                                state_q  <= after_q;
                            end
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        bitcnt_q <= bitcnt_q + CW'(1);
                    end else if (scl_fall) begin
                        if (bitcnt_q == CW'(BYTE_W)) begin
                            sda_oe_q <= 1'b0;
                            more_q   <= 1'b0;
                            state_q  <= ST_HACK;
                        end else begin
                            sda_oe_q <= ~tx_q[6];
                            tx_q     <= {tx_q[5:0], 1'b0};
                        end
                    end
                end
                ST_HACK: begin
                    if (scl_rise) begin
                        if (!sda_lvl) more_q  <= 1'b1;
                        else          state_q <= ST_SKIP;
                    end else if (scl_fall && more_q) begin
                        tx_q     <= reg_rdata[6:0];
                        sda_oe_q <= ~reg_rdata[7];
                        ptr_q    <= ptr_q + AW'(1);
                        bitcnt_q <= '0;
                        more_q   <= 1'b0;
                        state_q  <= ST_TX;
                    end
                end
                default: begin
                    // ST_IDLE and ST_SKIP: only a start or a stop moves on.
                end
            endcase
        end
    end

    // R11: the SDA enable moves only after an SCL fall, a start or a stop.
    p_oe_moves_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_q) |-> ($past(scl_fall) || $past(start_e) || $past(stop_e)));

    // R3: a stop always leaves SDA released.
    p_release_on_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stop_e |=> !sda_oe_q);

    // R5: every write strobe advances the pointer by one.
    p_wr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (reg_addr == AW'($past(reg_addr) + AW'(1))));

    // R6: every byte loaded for transmission advances the pointer by one.
    p_rd_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> (reg_addr == AW'($past(reg_addr) + AW'(1))));

    // R8: read strobe is a single-cycle pulse.
    p_rd_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd);

    // R8: strobes never overlap.
    p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd));

    // R1: an unaddressed or finished transfer keeps SDA released.
    p_skip_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SKIP) |-> !sda_oe_q);

endmodule

// File: rtl/i2c_regport_target.sv
// i2c_regport_target
// Top of the I2C target register access engine. It chains the line
// synchronizer and the byte engine, and exposes the open-drain SDA enable
// and the register strobe bus.
// Assumes: an external pad turns sda_oe into a pull-down. The register bank
// answers reg_rd combinationally on reg_rdata.
module i2c_regport_target #(
    parameter logic [6:0] DEV_ADDR    = 7'b1100000,
    parameter int         AW          = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe,
    output logic [AW-1:0] reg_addr,
    output logic [7:0]    reg_wdata,
    output logic          reg_wr,
    output logic          reg_rd,
    input  logic [7:0]    reg_rdata
);

    logic scl_rise;
    logic scl_fall;
    logic start_e;
    logic stop_e;
    logic sda_lvl;

    i2c_line_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_e  (start_e),
        .stop_e   (stop_e),
        .sda_lvl  (sda_lvl)
    );

    i2c_byte_engine #(
        .DEV_ADDR (DEV_ADDR),
        .AW       (AW)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_e   (start_e),
        .stop_e    (stop_e),
        .sda_lvl   (sda_lvl),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_rdata (reg_rdata)
    );

endmodule

// File: tb/i2c_regport_target_test.sv
// Directed bench: a bus master model drives SCL/SDA, and a register bank
// model answers the strobe bus and counts accesses.
module i2c_regport_target_test;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 20 * CLK_PERIOD;  // quarter SCL period
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_low = 1'b0;
    logic       sda_line;
    logic       sda_oe;
    logic [7:0] reg_addr;
    logic [7:0] reg_wdata;
    logic       reg_wr;
    logic       reg_rd;
    logic [7:0] reg_rdata;

    logic [7:0] bank [256];
    int         rd_cnt [256];
    int         wr_cnt = 0;
    int         checks = 0;
    int         errors = 0;
    int         r11_viol = 0;
    bit         watch_oe = 1'b0;
    bit         oe_seen = 1'b0;
    bit         done = 1'b0;
    logic       oe_prev = 1'b0;
    logic       scl_prev = 1'b1;

    assign sda_line  = ~(m_low | sda_oe);
    assign reg_rdata = bank[reg_addr];

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_regport_target uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (m_scl),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_rdata (reg_rdata)
    );

    function automatic logic [7:0] init_val(input int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    // Register bank model: stores writes, counts strobes per address.
    always @(posedge clk) begin
        if (reg_wr) begin
            bank[reg_addr] <= reg_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (reg_rd) rd_cnt[reg_addr] <= rd_cnt[reg_addr] + 1;
    end

    // Monitor: SDA enable must not change during an SCL high phase (R11).
    always @(negedge clk) begin
        if (rst_n && m_scl && scl_prev && (sda_oe !== oe_prev)) r11_viol++;
        if (watch_oe && sda_oe) oe_seen = 1'b1;
        oe_prev  = sda_oe;
        scl_prev = m_scl;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_start();
        m_low = 1'b1; #(Q);
        m_scl = 1'b0; #(Q);
    endtask

    task automatic do_rstart();
        m_low = 1'b0; #(Q);
        m_scl = 1'b1; #(Q);
        m_low = 1'b1; #(Q);
        m_scl = 1'b0; #(Q);
    endtask

    task automatic do_stop();
        m_low = 1'b1; #(Q);
        m_scl = 1'b1; #(Q);
        m_low = 1'b0; #(Q);
        #(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_low = ~b[i]; #(Q);
            m_scl = 1'b1; #(2*Q);
            m_scl = 1'b0; #(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        m_low = 1'b0; #(Q);
        m_scl = 1'b1; #(Q);
        ack = ~sda_line; #(Q);
        m_scl = 1'b0; #(Q);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            m_low = 1'b0; #(Q);
            m_scl = 1'b1; #(Q);
            b[i] = sda_line; #(Q);
            m_scl = 1'b0; #(Q);
        end
        m_low = give_ack; #(Q);
        m_scl = 1'b1; #(2*Q);
        m_scl = 1'b0; #(Q);
    endtask

    task automatic t_reset();
        check("R9 sda_oe after reset", int'(sda_oe), 0);
        check("R9 reg_wr after reset", int'(reg_wr), 0);
        check("R9 reg_rd after reset", int'(reg_rd), 0);
        check("R9 pointer after reset", int'(reg_addr), 0);
    endtask

    task automatic t_single_write();
        logic a;
        int w0 = wr_cnt;
        do_start();
        send_byte(8'hC0, a); check("R1 address ack", int'(a), 1);
        send_byte(8'h03, a); check("R4 pointer ack", int'(a), 1);
        send_byte(8'hA7, a); check("R2 data ack", int'(a), 1);
        do_stop();
        check("R5 single write value", int'(bank[3]), 8'hA7);
        check("R5 neighbour untouched", int'(bank[4]), int'(init_val(4)));
        check("R4 pointer byte not written", wr_cnt - w0, 1);
    endtask

    task automatic t_burst_write();
        logic a;
        int w0 = wr_cnt;
        do_start();
        send_byte(8'hC0, a);
        send_byte(8'h10, a);
        send_byte(8'h11, a);
        send_byte(8'h22, a);
        send_byte(8'h33, a); check("R5 burst ack", int'(a), 1);
        do_stop();
        check("R5 burst reg 0x10", int'(bank[8'h10]), 8'h11);
        check("R5 burst reg 0x11", int'(bank[8'h11]), 8'h22);
        check("R5 burst reg 0x12", int'(bank[8'h12]), 8'h33);
        check("R5 burst end untouched", int'(bank[8'h13]), int'(init_val(8'h13)));
        check("R5 burst write count", wr_cnt - w0, 3);
    endtask

    task automatic t_burst_read();
        logic a;
        logic [7:0] d;
        do_start();
        send_byte(8'hC0, a);
        send_byte(8'h10, a);
        do_rstart();
        send_byte(8'hC1, a); check("R1 read address ack", int'(a), 1);
        recv_byte(1'b1, d); check("R6 read byte 0 (R2 MSB first)", int'(d), 8'h11);
        recv_byte(1'b1, d); check("R6 read byte 1", int'(d), 8'h22);
        recv_byte(1'b0, d); check("R6 read byte 2", int'(d), 8'h33);
        check("R7 SDA released after host NACK", int'(sda_oe), 0);
        do_stop();
        check("R8 one read of 0x10", rd_cnt[8'h10], 1);
        check("R8 one read of 0x12", rd_cnt[8'h12], 1);
        check("R7 no load after NACK", rd_cnt[8'h13], 0);
        check("R6 pointer after read", int'(reg_addr), 8'h13);
    endtask

    task automatic t_ptr_keep();
        logic a;
        logic [7:0] d;
        do_start();
        send_byte(8'hC1, a);
        recv_byte(1'b0, d);
        do_stop();
        check("R10 pointer kept across stop", int'(d), int'(init_val(8'h13)));
        check("R8 single read of kept pointer", rd_cnt[8'h13], 1);
    endtask

    task automatic t_wrap();
        logic a;
        do_start();
        send_byte(8'hC0, a);
        send_byte(8'hFF, a);
        send_byte(8'h5A, a);
        send_byte(8'h6B, a);
        do_stop();
        check("R10 write at 0xFF", int'(bank[8'hFF]), 8'h5A);
        check("R10 wrap to 0x00", int'(bank[8'h00]), 8'h6B);
        check("R10 pointer after wrap", int'(reg_addr), 8'h01);
    endtask

    task automatic t_bad_addr();
        logic a;
        int w0 = wr_cnt;
        watch_oe = 1'b1;
        oe_seen  = 1'b0;
        do_start();
        send_byte(8'h82, a); check("R1 wrong address not acked", int'(a), 0);
        send_byte(8'h05, a);
        send_byte(8'h77, a); check("R1 later byte not acked", int'(a), 0);
        do_stop();
        watch_oe = 1'b0;
        check("R1 SDA never driven", int'(oe_seen), 0);
        check("R1 no write when unaddressed", wr_cnt - w0, 0);
        check("R1 reg 0x05 untouched", int'(bank[8'h05]), int'(init_val(5)));
    endtask

    task automatic t_stop_midbyte();
        logic a;
        int w0 = wr_cnt;
        do_start();
        send_byte(8'hC0, a);
        send_byte(8'h20, a);
        send_bits(8'hF0, 4);
        do_stop();
        check("R3 partial byte not written", wr_cnt - w0, 0);
        check("R3 SDA released after stop", int'(sda_oe), 0);
        do_start();
        send_byte(8'hC0, a); check("R3 address ack after abort", int'(a), 1);
        send_byte(8'h21, a);
        send_byte(8'hC3, a);
        do_stop();
        check("R3 write after abort", int'(bank[8'h21]), 8'hC3);
    endtask

    // Watchdog: a hung run counts as a failed check and still reports.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            bank[i]   = init_val(i);
            rd_cnt[i] = 0;
        end
        repeat (5) @(posedge clk);
        #2;
        rst_n = 1'b1;
        #(CLK_PERIOD);
        t_reset();
        #(Q);
        t_single_write();
        t_burst_write();
        t_burst_read();
        t_ptr_keep();
        t_wrap();
        t_bad_addr();
        t_stop_midbyte();
        check("R11 SDA steady while SCL high", r11_viol, 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule